// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and decides which one the CPU should hear about next. A rising edge on a request line latches a pending bit. A per-level mask keeps a level out of the contest. A fixed-priority resolver picks the most urgent unmasked pending level, where level 0 is the most urgent and level 7 the least. The block raises its interrupt line toward the CPU only when that candidate is more urgent than every level the CPU is already servicing. Interrupts can therefore nest, and a routine is never interrupted by an equal or less urgent source.

When the CPU acknowledges, the winning level leaves the pending set and joins the in-service set. One cycle later the block presents a vector byte that the CPU uses to find the routine for that level. A small write port sets the mask and the vector base, and it accepts a non-specific end-of-interrupt command. That command retires the most urgent in-service level, so less urgent levels can be recognised again.

Top module: `nest_intc`

## Requirements
- R1: After reset, int_req, vec_valid and vec_out are all 0, the mask is all zeros (every level enabled), the vector base is 0, and no level is pending or in service.
- R2: A 0-to-1 transition on irq_in[i] sets pending bit i at the next clock edge. A line held high does not raise a second request after its first request has been acknowledged.
- R3: A level whose mask bit is 1 never causes int_req. Its pending bit is kept, so clearing the mask bit later lets it raise int_req. The mask is written at cfg_addr 0, where bit i masks level i.
- R4: int_req is high exactly when some unmasked level is pending and the most urgent such level (lowest index) has a lower index than every level in service.
- R5: A cycle with int_ack high while int_req is high moves the winning level from pending to in-service. At the following clock edge vec_valid is high for one cycle.
- R6: The vector is {base[7:3], level[2:0]}. The base is written at cfg_addr 1, and only bits 7:3 are kept. vec_out holds its value until the next accepted acknowledge.
- R7: int_ack while int_req is low has no effect: vec_valid stays low and the pending and in-service sets are unchanged.
- R8: A write to cfg_addr 2, with any data, clears the lowest-index in-service bit. With nothing in service, it has no effect.
- R9: A configuration write takes effect at the next clock edge. A write to cfg_addr 3 changes nothing.
- R10: Same-cycle events: a new rising edge on the level being acknowledged leaves it pending again. An acknowledge and an end-of-interrupt in the same cycle both act, and the end-of-interrupt retires the most urgent level that was in service before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive, index = level |
| int_ack | input | 1 | CPU acknowledge, one cycle per accepted interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mask, 1 vector base, 2 end-of-interrupt, 3 unused |
| cfg_wdata | input | 8 | Configuration write data |
| int_req | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector byte of the last accepted acknowledge |
| vec_valid | output | 1 | High for one cycle when vec_out is new |

## Verification
Three pairs of events can land on the same clock edge. An acknowledge can coincide with a fresh rising edge on the winning line, or with an end-of-interrupt write, and a mask or base write can coincide with an acknowledge. Directed steps force each pair on purpose. Random stimulus then produces them many more times. In every case the bench's cycle model decides the outcome: a new edge wins over the acknowledge clear, the end-of-interrupt acts on the in-service set from before the edge, and the acknowledge uses the old mask and base. The bench then compares int_req, vec_valid and vec_out with that model.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
  localparam int unsigned LEVELS = 8;
  localparam int unsigned LVL_W  = $clog2(LEVELS);

  typedef logic [LEVELS-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0]  lvl_idx_t;

  // Keep only the lowest set bit (the most urgent level).
  function automatic lvl_vec_t lowest_bit(input lvl_vec_t v);
    return v & (~v + lvl_vec_t'(1));
  endfunction

  // Index of the single set bit of a one-hot vector (0 when empty).
  function automatic lvl_idx_t oh_to_idx(input lvl_vec_t oh);
    lvl_idx_t r;
    r = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (oh[i]) r = r | lvl_idx_t'(i);
    end
    return r;
  endfunction

  // A one-hot candidate outranks a one-hot ceiling when the ceiling is empty
  // or the candidate sits at a lower index.
  function automatic logic outranks(input lvl_vec_t cand, input lvl_vec_t ceil);
    return (|cand) && ((ceil == '0) || (cand < ceil));
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import nest_intc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t irq_in,
  input  lvl_vec_t take_oh,
  output lvl_vec_t pend_q,
  output lvl_vec_t rise
);
  lvl_vec_t irq_d;

  assign rise = irq_in & ~irq_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_d  <= '0;
      pend_q <= '0;
    end else begin
      irq_d  <= irq_in;
      // a fresh edge wins over the acknowledge clear of the same level
      pend_q <= (pend_q & ~take_oh) | rise;
    end
  end

  assert_edge_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import nest_intc_pkg::*;
(
  input  lvl_vec_t pend,
  input  lvl_vec_t mask,
  input  lvl_vec_t svc_top,
  output lvl_vec_t win_oh,
  output lvl_idx_t win_idx,
  output logic     eligible
);
  lvl_vec_t live;

  assign live     = pend & ~mask;
  assign win_oh   = lowest_bit(live);
  assign win_idx  = oh_to_idx(win_oh);
  assign eligible = outranks(win_oh, svc_top);
endmodule

// File: rtl/svc_tracker.sv
module svc_tracker
  import nest_intc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t enter_oh,
  input  logic     retire,
  output lvl_vec_t svc_q,
  output lvl_vec_t top_oh
);
  lvl_vec_t retire_oh;

  assign top_oh    = lowest_bit(svc_q);
  assign retire_oh = retire ? top_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= (svc_q & ~retire_oh) | enter_oh;
  end

  assert_eoi_retires_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && svc_q != '0 && enter_oh == '0)
      |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));
  assert_eoi_empty_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && svc_q == '0 && enter_oh == '0) |=> (svc_q == '0));
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              int_ack,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              int_req,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  localparam int unsigned BASE_W = DATA_W - LVL_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(2);

  lvl_vec_t          mask_q, pend_q, rise, svc_q, svc_top, win_oh, take_oh;
  lvl_idx_t          win_idx;
  logic [BASE_W-1:0] base_q;
  logic              eligible, ack_fire, eoi_cmd;

  assign ack_fire = int_ack && eligible;
  assign take_oh  = ack_fire ? win_oh : '0;
  assign eoi_cmd  = cfg_we && (cfg_addr == A_EOI);
  assign int_req  = eligible;

  irq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .take_oh(take_oh),
    .pend_q(pend_q), .rise(rise)
  );

  prio_resolver u_res (
    .pend(pend_q), .mask(mask_q), .svc_top(svc_top),
    .win_oh(win_oh), .win_idx(win_idx), .eligible(eligible)
  );

  svc_tracker u_svc (
    .clk(clk), .rst_n(rst_n), .enter_oh(take_oh), .retire(eoi_cmd),
    .svc_q(svc_q), .top_oh(svc_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_MASK) mask_q <= cfg_wdata[LEVELS-1:0];
      if (cfg_addr == A_BASE) base_q <= cfg_wdata[DATA_W-1:LVL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= ack_fire;
      if (ack_fire) vec_out <= {base_q, win_idx};
    end
  end

  assert_win_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));
  assert_win_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_oh & mask_q) == '0));
  assert_int_outranks_svc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((svc_q & ((win_oh << 1) - lvl_vec_t'(1))) == '0));
  assert_vec_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_fire));
  assert_ack_enters_svc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ((svc_q & $past(win_oh)) == $past(win_oh)));
  assert_ack_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ((rise & win_oh) == '0)) |=> ((pend_q & $past(win_oh)) == '0));
  assert_idle_ack_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !eoi_cmd) |=> ($stable(svc_q) && !vec_valid));
endmodule

// File: tb/nest_intc_tb_top.sv
module nest_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       int_ack, cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       int_req, vec_valid;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [7:0] m_pend, m_svc, m_mask, m_prev, m_vec;
  logic [4:0] m_base;
  logic       m_vv;

  always #10 clk = ~clk;  // 50 MHz

  nest_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_ack(int_ack),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // most urgent set bit, 8 when none
  function automatic int first_lvl(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic model_int();
    int p = first_lvl(m_pend & ~m_mask);
    int t = first_lvl(m_svc);
    return (p < 8) && (p < t);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(int_req === model_int(), {tag, " int_req"}, int_req, model_int());
    chk(vec_valid === m_vv, {tag, " vec_valid"}, vec_valid, m_vv);
    if (m_vv) chk(vec_out === m_vec, {tag, " vec_out"}, vec_out, m_vec);
  endtask

  // compare, drive one cycle of inputs, advance model and DUT one edge
  task automatic step(input logic [7:0] irq, input bit ack, input bit we,
                      input logic [1:0] addr, input logic [7:0] data, input string tag);
    int p, t;
    logic fire;
    logic [7:0] rise, n_pend, n_svc;
    compare(tag);
    irq_in = irq; int_ack = ack; cfg_we = we; cfg_addr = addr; cfg_wdata = data;
    p = first_lvl(m_pend & ~m_mask);
    t = first_lvl(m_svc);
    fire = ack && model_int();
    rise = irq & ~m_prev;
    n_pend = m_pend;
    n_svc  = m_svc;
    if (fire) begin
      n_pend[p] = 1'b0;
      n_svc[p]  = 1'b1;
    end
    n_pend = n_pend | rise;
    if (we && addr == 2'd2 && t < 8) n_svc[t] = 1'b0;
    if (fire && !(we && addr == 2'd2)) n_svc[p] = 1'b1;
    @(posedge clk);
    if (fire) m_vec = {m_base, 3'(p)};
    m_vv = fire;
    m_pend = n_pend;
    m_svc  = n_svc;
    m_prev = irq;
    if (we && addr == 2'd0) m_mask = data;
    if (we && addr == 2'd1) m_base = data[7:3];
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] irq_r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_in = '0; int_ack = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    m_pend = '0; m_svc = '0; m_mask = '0; m_prev = '0; m_vec = '0; m_base = '0; m_vv = 0;
    repeat (3) @(negedge clk);
    chk(int_req === 1'b0, "R1 int_req", int_req, 0);
    chk(vec_valid === 1'b0, "R1 vec_valid", vec_valid, 0);
    chk(vec_out === 8'h00, "R1 vec_out", vec_out, 0);
    rst_n = 1'b1;

    // R2: edge capture, held line does not re-request
    step(8'h00, 0, 0, 0, 0, "R2");
    step(8'h20, 0, 0, 0, 0, "R2");
    chk(int_req === 1'b1, "R2 edge raises int", int_req, 1);
    step(8'h20, 1, 0, 0, 0, "R5");
    chk(vec_valid === 1'b1 && vec_out === 8'h05, "R5 R6 vector lvl5", vec_out, 8'h05);
    step(8'h20, 0, 0, 0, 0, "R2");
    chk(int_req === 1'b0, "R2 held line quiet", int_req, 0);
    chk(vec_valid === 1'b0, "R5 vec_valid one cycle", vec_valid, 0);

    // R6 base, R4 nesting
    step(8'h20, 0, 1, 2'd1, 8'hAF, "R6");
    step(8'h28, 0, 0, 0, 0, "R4");
    chk(int_req === 1'b1, "R4 level3 outranks 5", int_req, 1);
    step(8'h28, 1, 0, 0, 0, "R4");
    chk(vec_out === 8'hAB, "R6 base upper bits", vec_out, 8'hAB);
    step(8'h68, 0, 0, 0, 0, "R4");
    chk(int_req === 1'b0, "R4 level6 blocked", int_req, 0);
    step(8'h68, 0, 1, 2'd2, 8'h00, "R8");
    chk(int_req === 1'b0, "R8 level5 still blocks 6", int_req, 0);
    step(8'h68, 0, 1, 2'd2, 8'h55, "R8");
    chk(int_req === 1'b1, "R8 level6 recognised", int_req, 1);
    step(8'h68, 1, 0, 0, 0, "R5");
    step(8'h00, 0, 1, 2'd2, 0, "R8");
    step(8'h00, 0, 1, 2'd2, 0, "R8 empty");
    step(8'h80, 0, 0, 0, 0, "R8");
    chk(int_req === 1'b1, "R8 empty eoi harmless", int_req, 1);
    step(8'h80, 1, 0, 0, 0, "R5");
    step(8'h00, 0, 1, 2'd2, 0, "R8");

    // R3 mask
    step(8'h00, 0, 1, 2'd0, 8'h02, "R3");
    step(8'h02, 0, 0, 0, 0, "R3");
    step(8'h02, 0, 0, 0, 0, "R3");
    chk(int_req === 1'b0, "R3 masked level", int_req, 0);
    step(8'h02, 0, 1, 2'd0, 8'h00, "R9");
    chk(int_req === 1'b1, "R3 R9 unmask next edge", int_req, 1);
    step(8'h02, 1, 0, 0, 0, "R5");
    step(8'h00, 0, 1, 2'd2, 0, "R8");

    // R7 idle ack, R9 unused address
    step(8'h00, 1, 0, 0, 0, "R7");
    chk(vec_valid === 1'b0, "R7 idle ack ignored", vec_valid, 0);
    step(8'h00, 0, 1, 2'd3, 8'hFF, "R9");
    step(8'h10, 0, 0, 0, 0, "R9");
    chk(int_req === 1'b1, "R9 addr3 left mask", int_req, 1);

    // R10: edge on winner during ack, then ack with eoi
    step(8'h00, 0, 0, 0, 0, "R10");
    step(8'h10, 1, 0, 0, 0, "R10");
    chk(int_req === 1'b0, "R10 level4 repending but in service", int_req, 0);
    step(8'h10, 0, 1, 2'd2, 0, "R10");
    chk(int_req === 1'b1, "R10 re-edge kept pending", int_req, 1);
    step(8'h14, 1, 0, 0, 0, "R10");
    step(8'h15, 0, 0, 0, 0, "R10");
    step(8'h15, 1, 1, 2'd2, 0, "R10");
    chk(vec_out === 8'hA8, "R10 ack with eoi vector", vec_out, 8'hA8);
    step(8'h15, 0, 1, 2'd2, 0, "R10");
    chk(int_req === 1'b1, "R10 eoi retired old top", int_req, 1);

    // random traffic
    irq_r = 8'h15;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] flip;
      bit ack, we;
      logic [1:0] a;
      logic [7:0] d;
      flip = 8'($urandom) & 8'($urandom) & 8'($urandom);
      irq_r = irq_r ^ flip;
      ack = ($urandom % 4) == 0;
      we  = ($urandom % 6) == 0;
      a   = 2'($urandom);
      d   = 8'($urandom);
      if (a == 2'd0) d = d & 8'($urandom);
      step(irq_r, ack, we, a, d, "R2 R3 R4 R5 R8 R10 random");
    end
    compare("R4 final");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule